// File: doc/BRIEF.md
# Multiplexed Bus Cycle Controller

This block runs one external transfer at a time over a bus whose sixteen low lines carry first the address and then data, and whose four high lines carry the top of the address and then status. A client raises a request with a 20-bit address and selects read or write, memory or I/O space, and byte or word size. The controller then walks the phases T1, T2, T3, any wait clocks and T4. It produces the address strobe, the read and write strobes, the transceiver direction and enable, and the high-byte enable. On a read it returns the collected data with a one-clock completion pulse.

Each byte lane maps to one memory bank. A byte at an even address travels on the low lane, and a byte at an odd address travels on the high lane. A word at an odd address is broken into two complete bus cycles. Slow targets stretch a transfer by holding the ready input low. Reset ends any transfer at once.

Top module: `mux_bus_ctrl`

## Requirements
- R1: A transfer runs at least four clocks in the order T1, T2, T3, T4. The controller reports busy from T1 until the end of the final T4. `done` is high for exactly the final T4 clock.
- R2: During T1 only, `ale` is high for one clock and `ad_out[19:0]` equals the transfer address. In that clock `ad_oe` is 1 and both `rd_n` and `wr_n` are 1.
- R3: `ready` is sampled at the clock edge that ends T3 and at the edge that ends each wait clock. Every low sample adds one wait clock before T4, and the active strobe stays low through all wait clocks.
- R4: While busy, `m_io` is 1 for memory space and 0 for I/O space. `dt_r` is 1 for writes and 0 for reads. `den_n` is 0 from T2 through T4.
- R5: For a read, `rd_n` is low from T2 through the last T3 or wait clock. For a write, `wr_n` is low over the same clocks. The two strobes are never low together.
- R6: After T1 and until the end of the cycle, `ad_out[19]` is 0, `ad_out[18]` is the interrupt-enable flag, and `ad_out[17:16]` is the segment code. Both values are captured when the request is accepted.
- R7: Lane select works as follows. A word at an even address drives `bhe_n`=0 and `ad_out[0]`=0. A byte at an even address drives `bhe_n`=1 and uses bits 7:0. A byte at an odd address drives `bhe_n`=0 and uses bits 15:8. A byte read returns the lane zero-extended in `rdata[7:0]`.
- R8: On a read, `ad_oe` is 0 from T2 through T4, and `ad_in` is captured at the edge where `ready` is sampled high. `rdata` holds that value during the final T4. On a write, `ad_oe` is 1 from T2 through T4 and the write data sits on the selected lane.
- R9: A word at an odd address A becomes two full bus cycles. The first uses address A and the high lane, and carries data bits 7:0. The second uses address A+1 modulo 2^20 and the low lane, and carries data bits 15:8. `done` fires only at the end of the second cycle.
- R10: A request is accepted only while the controller is idle. A request raised while busy is ignored and starts no transfer.
- R11: While `rst` is high, any transfer is abandoned. On the clock after release the controller is idle with `ale`=0, `rd_n`=`wr_n`=`den_n`=`bhe_n`=1 and `ad_oe`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Transfer request, taken when idle |
| addr | input | 20 | Transfer address |
| is_write | input | 1 | 1 = write, 0 = read |
| is_mem | input | 1 | 1 = memory space, 0 = I/O space |
| is_word | input | 1 | 1 = 16-bit transfer, 0 = byte |
| wdata | input | 16 | Write data; a byte write uses bits 7:0 |
| ad_in | input | 16 | Value seen on the shared lines during reads |
| ready | input | 1 | Target ready, sampled in T3 and wait clocks |
| ie_flag | input | 1 | Interrupt-enable flag for the status bits |
| seg_code | input | 2 | Segment in use for the status bits |
| ad_out | output | 20 | Driven value of the shared and high lines |
| ad_oe | output | 1 | Drive enable of the sixteen shared lines |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| m_io | output | 1 | Memory (1) or I/O (0) space |
| dt_r | output | 1 | Transceiver direction, 1 = transmit |
| den_n | output | 1 | Transceiver enable, active low |
| bhe_n | output | 1 | High byte enable, active low |
| rdata | output | 16 | Read result |
| done | output | 1 | One-clock completion pulse |
| busy | output | 1 | Transfer in progress |

## Verification
The hardest case to reach is the split word at an odd address. Its second half must follow the first without returning to idle, and it must carry the incremented address. When it starts at the top of the address space, that address wraps to zero. The vector table includes split reads and split writes, one of them at the last address, with wait clocks in one of the halves. The bench checks each T1 address, the lane and byte order, and the reassembled read word. A reset raised in the middle of a wait clock and a request raised during T2 are produced by directed sequences. These sequences hold `ready` low and raise the extra request at the chosen clock.

// File: rtl/mux_bus_ctrl.sv
module mux_bus_ctrl #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic [ADDR_W-1:0] addr,
  input  logic              is_write,
  input  logic              is_mem,
  input  logic              is_word,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] ad_in,
  input  logic              ready,
  input  logic              ie_flag,
  input  logic [1:0]        seg_code,
  output logic [ADDR_W-1:0] ad_out,
  output logic              ad_oe,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic              m_io,
  output logic              dt_r,
  output logic              den_n,
  output logic              bhe_n,
  output logic [DATA_W-1:0] rdata,
  output logic              done,
  output logic              busy
);
  localparam int BW   = DATA_W / 2;
  localparam int HI_W = ADDR_W - DATA_W;

  typedef enum logic [2:0] {S_IDLE, S_T1, S_T2, S_T3, S_TW, S_T4} phase_t;
  phase_t st;

  logic [ADDR_W-1:0] a_q;
  logic [DATA_W-1:0] wd_q, rd_q;
  logic              wr_q, mem_q, word_q, split_q, part2_q, ie_q;
  logic [1:0]        seg_q;

  wire last_part = !split_q || part2_q;
  wire data_ph   = (st == S_T2) || (st == S_T3) || (st == S_TW) || (st == S_T4);
  wire strobe_ph = (st == S_T2) || (st == S_T3) || (st == S_TW);
  wire sample    = ((st == S_T3) || (st == S_TW)) && ready && !wr_q;
  wire full_word = word_q && !split_q;

  wire [BW-1:0]     wbyte  = part2_q ? wd_q[DATA_W-1:BW] : wd_q[BW-1:0];
  wire [DATA_W-1:0] wbus   = full_word ? wd_q : {wbyte, wbyte};
  wire [BW-1:0]     rlane  = a_q[0] ? ad_in[DATA_W-1:BW] : ad_in[BW-1:0];
  wire [HI_W-1:0]   status = {{(HI_W-3){1'b0}}, ie_q, seg_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      a_q     <= '0;
      wd_q    <= '0;
      rd_q    <= '0;
      wr_q    <= 1'b0;
      mem_q   <= 1'b0;
      word_q  <= 1'b0;
      split_q <= 1'b0;
      part2_q <= 1'b0;
      ie_q    <= 1'b0;
      seg_q   <= '0;
    end else begin
      case (st)
        S_IDLE: if (req) begin
          a_q     <= addr;
          wd_q    <= wdata;
          wr_q    <= is_write;
          mem_q   <= is_mem;
          word_q  <= is_word;
          split_q <= is_word && addr[0];
          part2_q <= 1'b0;
          ie_q    <= ie_flag;
          seg_q   <= seg_code;
          st      <= S_T1;
        end
        S_T1: st <= S_T2;
        S_T2: st <= S_T3;
        S_T3, S_TW: st <= ready ? S_T4 : S_TW;
        S_T4: if (!last_part) begin
          part2_q <= 1'b1;
          a_q     <= a_q + ADDR_W'(1);
          st      <= S_T1;
        end else begin
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase

      if (sample) begin
        if (full_word)    rd_q <= ad_in;
        else if (!split_q) rd_q <= {{BW{1'b0}}, rlane};
        else if (part2_q) rd_q[DATA_W-1:BW] <= rlane;
        else              rd_q[BW-1:0] <= rlane;
      end
    end
  end

  assign busy   = (st != S_IDLE);
  assign ale    = (st == S_T1);
  assign ad_oe  = ale || (wr_q && data_ph);
  assign ad_out = !busy ? '0 : ale ? a_q : {status, wr_q ? wbus : {DATA_W{1'b0}}};
  assign rd_n   = !(strobe_ph && !wr_q);
  assign wr_n   = !(strobe_ph && wr_q);
  assign den_n  = !data_ph;
  assign m_io   = mem_q;
  assign dt_r   = wr_q;
  assign bhe_n  = busy ? !(full_word || a_q[0]) : 1'b1;
  assign rdata  = rd_q;
  assign done   = (st == S_T4) && last_part;
endmodule

// File: rtl/mux_bus_ctrl_chk.sv
module mux_bus_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic ready,
  input logic ale,
  input logic rd_n,
  input logic wr_n,
  input logic ad_oe,
  input logic dt_r,
  input logic den_n,
  input logic s6,
  input logic done,
  input logic busy
);
  assert_ale_one_clock_R2: assert property (@(posedge clk) disable iff (rst)
    ale |=> !ale);
  assert_ale_quiet_strobes_R2: assert property (@(posedge clk) disable iff (rst)
    ale |-> (rd_n && wr_n && ad_oe));
  assert_strobes_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_n || wr_n));
  assert_wait_stretch_R3: assert property (@(posedge clk) disable iff (rst)
    (!(rd_n && wr_n) && !ready) |=> !(rd_n && wr_n));
  assert_read_released_R8: assert property (@(posedge clk) disable iff (rst)
    !rd_n |-> (!ad_oe && !dt_r && !den_n));
  assert_write_driven_R8: assert property (@(posedge clk) disable iff (rst)
    !wr_n |-> (ad_oe && dt_r && !den_n));
  assert_status_low_bit_R6: assert property (@(posedge clk) disable iff (rst)
    (busy && !ale) |-> !s6);
  assert_done_pulse_R1: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done && !busy));
  assert_no_restart_R10: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> busy);
  assert_reset_idle_R11: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rd_n && wr_n && !ale && !busy && den_n));
endmodule

bind mux_bus_ctrl mux_bus_ctrl_chk i_chk (
  .clk(clk), .rst(rst), .ready(ready), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
  .ad_oe(ad_oe), .dt_r(dt_r), .den_n(den_n), .s6(ad_out[ADDR_W-1]),
  .done(done), .busy(busy)
);

// File: tb/test_mux_bus_ctrl.sv
`timescale 1ns/1ps
module test_mux_bus_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic [19:0] addr = '0;
  logic        is_write = 1'b0, is_mem = 1'b0, is_word = 1'b0;
  logic [15:0] wdata = '0, ad_in = '0;
  logic        ready = 1'b1, ie_flag = 1'b0;
  logic [1:0]  seg_code = '0;
  logic [19:0] ad_out;
  logic        ad_oe, ale, rd_n, wr_n, m_io, dt_r, den_n, bhe_n, done, busy;
  logic [15:0] rdata;

  int nchk = 0, nerr = 0;

  always #2 clk = ~clk;

  mux_bus_ctrl i_mux_bus_ctrl (
    .clk(clk), .rst(rst), .req(req), .addr(addr), .is_write(is_write),
    .is_mem(is_mem), .is_word(is_word), .wdata(wdata), .ad_in(ad_in),
    .ready(ready), .ie_flag(ie_flag), .seg_code(seg_code), .ad_out(ad_out),
    .ad_oe(ad_oe), .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .m_io(m_io),
    .dt_r(dt_r), .den_n(den_n), .bhe_n(bhe_n), .rdata(rdata), .done(done),
    .busy(busy)
  );

  typedef struct packed {
    logic        wr;
    logic        mem;
    logic        word;
    logic [19:0] a;
    logic [15:0] wd;
    logic [1:0]  waits;
    logic [15:0] busv;
    logic [15:0] exp_rd;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b1, 1'b1, 20'h12344, 16'h0000, 2'd0, 16'hBEEF, 16'hBEEF},
    '{1'b0, 1'b0, 1'b0, 20'h00051, 16'h0000, 2'd2, 16'hA55A, 16'h00A5},
    '{1'b0, 1'b1, 1'b0, 20'hFFFFE, 16'h0000, 2'd1, 16'h1234, 16'h0034},
    '{1'b1, 1'b1, 1'b1, 20'h00100, 16'hCAFE, 2'd0, 16'h0000, 16'h0000},
    '{1'b1, 1'b0, 1'b0, 20'h00203, 16'h0077, 2'd1, 16'h0000, 16'h0000},
    '{1'b0, 1'b1, 1'b1, 20'h3000F, 16'h0000, 2'd1, 16'h1357, 16'h5713},
    '{1'b1, 1'b1, 1'b1, 20'hFFFFF, 16'hAB12, 2'd0, 16'h0000, 16'h0000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v, input logic ie, input logic [1:0] sg, input bit poke);
    bit split = v.word && v.a[0];
    @(negedge clk);
    addr = v.a; is_write = v.wr; is_mem = v.mem; is_word = v.word;
    wdata = v.wd; ie_flag = ie; seg_code = sg; req = 1'b1; ready = 1'b1;
    @(posedge clk);
    for (int p = 0; p < (split ? 2 : 1); p++) begin
      logic [19:0] pa = (p == 1) ? v.a + 20'd1 : v.a;
      logic exp_bhe = !((v.word && !split) || pa[0]);
      bit last = (p == (split ? 1 : 0));
      @(negedge clk);
      req = 1'b0; addr = 20'h0AAAA; ie_flag = !ie; seg_code = ~sg;
      chk("R2 ale in T1", ale, 1);
      chk("R2/R9 T1 address", ad_out, pa);
      chk("R2 T1 strobes idle", {ad_oe, rd_n, wr_n}, 3'b111);
      chk("R7 bhe_n", bhe_n, exp_bhe);
      chk("R4 m_io/dt_r", {m_io, dt_r}, {v.mem, v.wr});
      chk("R1 busy", busy, 1);
      @(posedge clk);
      @(negedge clk);
      if (poke) begin req = 1'b1; addr = 20'h55555; end
      chk("R2 ale low in T2", ale, 0);
      chk("R6 status bits", ad_out[19:16], {1'b0, ie, sg});
      chk("R5 strobes T2", {rd_n, wr_n}, {v.wr, !v.wr});
      chk("R4 den_n T2", den_n, 0);
      chk("R8 drive enable T2", ad_oe, v.wr);
      if (v.wr) begin
        if (v.word && !split) chk("R8 word write data", ad_out[15:0], v.wd);
        else chk("R7/R9 write lane", pa[0] ? ad_out[15:8] : ad_out[7:0],
                 (p == 1) ? v.wd[15:8] : v.wd[7:0]);
      end
      ready = (v.waits == 0); ad_in = v.busv;
      @(posedge clk);
      for (int w = 0; w <= v.waits; w++) begin
        @(negedge clk);
        req = 1'b0;
        ready = (w == v.waits);
        chk("R3 strobe held", {rd_n, wr_n}, {v.wr, !v.wr});
        chk("R8 drive enable T3", ad_oe, v.wr);
        chk("R1 no early done", done, 0);
        @(posedge clk);
      end
      @(negedge clk);
      ad_in = 16'h0;
      chk("R1 T4 done", done, last);
      chk("R5 strobes off T4", {rd_n, wr_n}, 2'b11);
      chk("R4 den_n T4", den_n, 0);
      if (last && !v.wr) chk("R8/R7/R9 read data", rdata, v.exp_rd);
      @(posedge clk);
    end
    @(negedge clk);
    chk("R10 idle after done", {busy, ale, done}, 3'b000);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk("R11 reset state", {ale, rd_n, wr_n, den_n, bhe_n, ad_oe, busy, done}, 8'b01111000);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 idle after release", {ale, rd_n, wr_n, busy}, 4'b0110);

    for (int i = 0; i < NV; i++) run_vec(VEC[i], i[0], i[1:0], 1'b0);

    run_vec(VEC[0], 1'b1, 2'b10, 1'b1);

    @(negedge clk);
    addr = 20'h00051; is_write = 1'b0; is_mem = 1'b0; is_word = 1'b0;
    req = 1'b1; ready = 1'b0;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R3 waiting while ready low", rd_n, 0);
    rst = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0; ready = 1'b1;
    @(negedge clk);
    chk("R11 abort strobes", {ale, rd_n, wr_n, den_n, bhe_n, ad_oe, busy}, 7'b0111100);
    run_vec(VEC[5], 1'b0, 2'b11, 1'b0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule